// File: doc/BRIEF.md
# PCI Express Configuration Window Decoder

This block owns the 64-bit base register that places the memory-mapped PCI Express configuration window in the physical address map. Software-side logic updates the register one byte at a time through a write strobe, a byte index and a data byte. On every such write the block re-derives the window it describes: whether it is switched on, its size (256, 128 or 64 MiB) and its base address, aligned to that size. The decoded window sits in registers and drives three plain status outputs.

A 64-bit physical address presented on the lookup input is compared against the decoded window without any clock delay. On a hit the block splits the offset into the window into the bus, device, function and register fields of a configuration access. On a miss all four fields read zero. The write port has no back-pressure: it carries no ready, every strobed byte is taken on the clock edge where it is presented, and the window outputs show the result one edge later. The lookup path carries no valid or ready either, since it is a pure function of the address and the registered window.

A write that leaves the length field at its reserved code does not change the decoded window. The block flags it with a one-cycle error pulse.

Top module: `ecam_window_dec`

## Requirements
- R1: After reset, the window is disabled, its base is 0xB000_0000, its size is 256 MiB, the error flag is low and no address hits.
- R2: A write with byte index k replaces register bits 8k+7..8k. The decoded enable, base and size reflect that write from the first clock edge after the strobe onward.
- R3: Register bit 0 is the window enable. While the decoded enable is low, the hit output is low for every address.
- R4: Register bits 2:1 are the length code: 00 selects 256 MiB, 01 selects 128 MiB and 10 selects 64 MiB. The size output gives the window length in bytes.
- R5: The decoded base keeps register bits 39:28 for 256 MiB. It also keeps bit 27 for 128 MiB, and bits 27 and 26 for 64 MiB. All other register bits read as zero in the base.
- R6: A write that leaves length code 11 in the register keeps the previous enable, base and size unchanged. It raises the error flag for exactly the one cycle that follows the write edge.
- R7: The hit output is high exactly when the decoded enable is set and base <= address < base + size. It follows the address input within the same cycle.
- R8: On a hit, offset = address - base, and the outputs are bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. On a miss all four read zero.
- R9: The bus number is bounded by the window size: at most 127 for 128 MiB and at most 63 for 64 MiB.
- R10: A write to any of the eight bytes re-decodes the whole register. A write to an upper byte therefore raises the error flag again while the length code is still reserved. Once the code is valid, such a write re-decodes without changing the base when it touches only bits the base ignores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 3 | Byte lane of the register to write |
| wr_data | input | 8 | Byte value to write |
| addr_i | input | 64 | Physical address to look up |
| win_en | output | 1 | Decoded window enable |
| win_base | output | 64 | Decoded, size-aligned window base |
| win_size | output | 64 | Window length in bytes |
| len_err | output | 1 | One-cycle pulse after a write that leaves the reserved length code |
| hit | output | 1 | Address lies inside the enabled window |
| bus_num | output | 8 | Bus number of a hit |
| dev_num | output | 5 | Device number of a hit |
| fn_num | output | 3 | Function number of a hit |
| reg_off | output | 12 | Register offset of a hit |

## Verification
The bench probes the first and last byte of each window size and the bytes just outside it. A base mask that drops bit 27 or 26, or keeps too many bits, shows up as a missed hit or a wrong bus number at the top of the window. It writes the reserved length code and then an upper byte with the code still reserved. A design that decodes the reserved code anyway would move the window, and a design that only re-decodes on writes to byte 0 would miss the second error pulse. It also writes bytes whose bits the base must ignore and presents addresses with high bits set. A decoder that compares too few address bits would then report false hits. Finally it clears the enable, which must silence every hit.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int PA_W      = 64;  // physical address width
  localparam int REG_BYTES = 8;   // bytes in the base register
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int OFF_W     = 12;

  typedef enum logic [1:0] {
    LEN_256 = 2'b00,
    LEN_128 = 2'b01,
    LEN_64  = 2'b10,
    LEN_RSV = 2'b11
  } len_code_e;

  typedef struct packed {
    logic            en;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] size;
  } win_t;
endpackage

// File: rtl/ecam_cfg_reg.sv
module ecam_cfg_reg
  import ecam_pkg::*;
#(
  parameter logic [PA_W-1:0] RESET_VALUE = 64'h0000_0000_B000_0000,
  localparam int IDX_W = $clog2(REG_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  output logic [PA_W-1:0] raw_next,
  output logic            upd
);
  logic [PA_W-1:0] raw_q;

  // one lane per byte; the strobed lane takes the new byte
  for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
    assign raw_next[b*8 +: 8] = (wr_en && (wr_idx == IDX_W'(b))) ? wr_data
                                                                 : raw_q[b*8 +: 8];
  end

  assign upd = wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= RESET_VALUE;
    else        raw_q <= raw_next;
  end
endmodule

// File: rtl/ecam_win_decode.sv
module ecam_win_decode
  import ecam_pkg::*;
#(
  parameter logic [PA_W-1:0] RESET_VALUE = 64'h0000_0000_B000_0000,
  parameter int ADDR_HI  = 39,  // highest base bit kept
  parameter int LOG2_MAX = 28   // log2 of the largest window
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [PA_W-1:0] raw_next,
  output win_t            win_q,
  output logic            err_q
);
  function automatic win_t decode(input logic [PA_W-1:0] r);
    win_t d;
    int   lowb;
    case (len_code_e'(r[2:1]))
      LEN_128: lowb = LOG2_MAX - 1;
      LEN_64:  lowb = LOG2_MAX - 2;
      default: lowb = LOG2_MAX;
    endcase
    d.en   = r[0];
    d.size = PA_W'(1) << lowb;
    for (int i = 0; i < PA_W; i++)
      d.base[i] = r[i] && (i >= lowb) && (i <= ADDR_HI);
    return d;
  endfunction

  win_t nxt;
  logic rsv;

  always_comb begin
    nxt = decode(raw_next);
    rsv = (len_code_e'(raw_next[2:1]) == LEN_RSV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= decode(RESET_VALUE);
      err_q <= 1'b0;
    end else begin
      err_q <= upd && rsv;
      if (upd && !rsv) win_q <= nxt;
    end
  end
endmodule

// File: rtl/ecam_addr_match.sv
module ecam_addr_match
  import ecam_pkg::*;
(
  input  logic             [PA_W-1:0] addr_i,
  input  win_t                        win,
  output logic                        hit,
  output logic             [BUS_W-1:0] bus_num,
  output logic             [DEV_W-1:0] dev_num,
  output logic             [FN_W-1:0]  fn_num,
  output logic             [OFF_W-1:0] reg_off
);
  localparam int DEV_LO = OFF_W + FN_W;
  localparam int BUS_LO = DEV_LO + DEV_W;

  logic [PA_W-1:0] lo_mask;
  logic [PA_W-1:0] off;

  always_comb begin
    lo_mask = win.size - PA_W'(1);
    off     = addr_i & lo_mask;
    hit     = win.en && ((addr_i & ~lo_mask) == win.base);
    bus_num = hit ? off[BUS_LO +: BUS_W] : '0;
    dev_num = hit ? off[DEV_LO +: DEV_W] : '0;
    fn_num  = hit ? off[OFF_W +: FN_W]   : '0;
    reg_off = hit ? off[0 +: OFF_W]      : '0;
  end
endmodule

// File: rtl/ecam_window_dec.sv
module ecam_window_dec
  import ecam_pkg::*;
#(
  parameter logic [PA_W-1:0] RESET_VALUE = 64'h0000_0000_B000_0000,
  parameter int ADDR_HI  = 39,
  parameter int LOG2_MAX = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [7:0]  wr_data,
  input  logic [63:0] addr_i,
  output logic        win_en,
  output logic [63:0] win_base,
  output logic [63:0] win_size,
  output logic        len_err,
  output logic        hit,
  output logic [7:0]  bus_num,
  output logic [4:0]  dev_num,
  output logic [2:0]  fn_num,
  output logic [11:0] reg_off
);
  logic [PA_W-1:0] raw_next;
  logic            upd;
  win_t            win;

  ecam_cfg_reg #(.RESET_VALUE(RESET_VALUE)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .raw_next(raw_next), .upd(upd)
  );

  ecam_win_decode #(
    .RESET_VALUE(RESET_VALUE), .ADDR_HI(ADDR_HI), .LOG2_MAX(LOG2_MAX)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .upd(upd), .raw_next(raw_next),
    .win_q(win), .err_q(len_err)
  );

  ecam_addr_match u_match (
    .addr_i(addr_i), .win(win), .hit(hit), .bus_num(bus_num),
    .dev_num(dev_num), .fn_num(fn_num), .reg_off(reg_off)
  );

  assign win_en   = win.en;
  assign win_base = win.base;
  assign win_size = win.size;
endmodule

// File: rtl/ecam_window_chk.sv
module ecam_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] addr_i,
  input logic        win_en,
  input logic [63:0] win_base,
  input logic [63:0] win_size,
  input logic        len_err,
  input logic        hit,
  input logic [7:0]  bus_num,
  input logic [4:0]  dev_num,
  input logic [2:0]  fn_num,
  input logic [11:0] reg_off
);
  p_no_hit_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !hit);

  p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1 && win_size >= 64'h0400_0000 && win_size <= 64'h1000_0000);

  p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base & (win_size - 64'd1)) == 64'd0 && win_base[63:40] == 24'd0);

  p_hold_on_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $stable(win_en) && $stable(win_base) && $stable(win_size));

  p_err_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(wr_en));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(win_en) && $stable(win_base) && $stable(win_size));

  p_hit_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> addr_i >= win_base && addr_i < win_base + win_size);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_num == 8'd0 && dev_num == 5'd0 && fn_num == 3'd0 && reg_off == 12'd0);

  p_bus_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_size == 64'h0400_0000) |-> bus_num < 8'd64);
endmodule

bind ecam_window_dec ecam_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_i(addr_i),
  .win_en(win_en), .win_base(win_base), .win_size(win_size),
  .len_err(len_err), .hit(hit), .bus_num(bus_num), .dev_num(dev_num),
  .fn_num(fn_num), .reg_off(reg_off)
);

// File: tb/sim_ecam_window_dec.sv
module sim_ecam_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [63:0] addr_i = '0;
  logic        win_en, len_err, hit;
  logic [63:0] win_base, win_size;
  logic [7:0]  bus_num;
  logic [4:0]  dev_num;
  logic [2:0]  fn_num;
  logic [11:0] reg_off;

  always #2 clk = ~clk;  // 250 MHz

  ecam_window_dec u0 (.*);

  typedef struct packed {
    logic        en;
    logic [63:0] base;
    logic [63:0] size;
    logic        err;
    logic        hit;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] rg;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  // model of the register and window, written from the requirements
  logic [63:0] m_raw = 64'h0000_0000_B000_0000;
  logic        m_en = 1'b0;
  logic [63:0] m_base = 64'hB000_0000;
  logic [63:0] m_size = 64'h1000_0000;
  logic        m_err = 1'b0;

  task automatic wr_byte(input logic [2:0] idx, input logic [7:0] val);
    int lg;
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    m_raw[idx*8 +: 8] = val;
    if (m_raw[2:1] == 2'b11) m_err = 1'b1;
    else begin
      m_err  = 1'b0;
      lg     = (m_raw[2:1] == 2'b00) ? 28 : (m_raw[2:1] == 2'b01) ? 27 : 26;
      m_en   = m_raw[0];
      m_size = 64'd1 << lg;
      m_base = m_raw & (64'hFF_FFFF_FFFF & ~(m_size - 64'd1));
    end
  endtask

  task automatic probe(input logic [63:0] a, input string tag);
    obs_t  e;
    logic [63:0] off;
    addr_i = a;
    e.en   = m_en;
    e.base = m_base;
    e.size = m_size;
    e.err  = m_err;
    e.hit  = m_en && (a >= m_base) && (a < m_base + m_size);
    off    = a - m_base;
    e.bus  = e.hit ? off[27:20] : '0;
    e.dev  = e.hit ? off[19:15] : '0;
    e.fn   = e.hit ? off[14:12] : '0;
    e.rg   = e.hit ? off[11:0]  : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_err = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares after the inputs have settled, away from clock edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        obs_t  e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = '{win_en, win_base, win_size, len_err, hit, bus_num, dev_num, fn_num, reg_off};
        n_tests++;
        if (g !== e) begin
          n_fail++;
          $display("FAIL %s: got en=%0b base=%h size=%h err=%0b hit=%0b bus=%0d dev=%0d fn=%0d reg=%h, expected en=%0b base=%h size=%h err=%0b hit=%0b bus=%0d dev=%0d fn=%0d reg=%h",
                   t, g.en, g.base, g.size, g.err, g.hit, g.bus, g.dev, g.fn, g.rg,
                   e.en, e.base, e.size, e.err, e.hit, e.bus, e.dev, e.fn, e.rg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got no end of run, expected end within 20000 cycles");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe(64'hB000_0000, "R1 reset state, window off");
    probe(64'hB123_4567, "R3 disabled window never hits");

    wr_byte(3'd0, 8'h01);                         // enable, 256 MiB
    probe(64'hB000_0000, "R2 R7 first byte hits");
    probe(64'hBFFF_FFFF, "R8 last byte fields");
    probe(64'hC000_0000, "R7 one past end misses");
    probe(64'hAFFF_FFFF, "R7 below base misses");
    probe(64'hB3A5_D123, "R8 mid-window split");

    wr_byte(3'd3, 8'hE8);                         // base bits 31:24
    probe(64'hE000_0000, "R5 256 MiB drops bit 27");
    wr_byte(3'd0, 8'h03);                         // 128 MiB
    probe(64'hE800_0000, "R4 R5 128 MiB keeps bit 27");
    probe(64'hEFFF_FFFF, "R9 bus bounded at 127");
    probe(64'hE7FF_FFFF, "R7 128 MiB below base");

    wr_byte(3'd3, 8'hEC);
    wr_byte(3'd0, 8'h05);                         // 64 MiB
    probe(64'hEFFF_FFFF, "R9 bus bounded at 63");
    probe(64'hEC00_0000, "R4 R5 64 MiB base");
    probe(64'hF000_0000, "R7 64 MiB past end");

    wr_byte(3'd0, 8'h07);                         // reserved length
    probe(64'hEC00_1000, "R6 reserved code holds window, flags");
    probe(64'hEC00_1000, "R6 error flag lasts one cycle");
    wr_byte(3'd4, 8'h12);                         // still reserved
    probe(64'h12_EC00_0000, "R10 upper byte write re-flags, window held");

    wr_byte(3'd0, 8'h01);                         // 256 MiB, base 0x12_E000_0000
    probe(64'h12_E000_0000, "R5 R10 base above 4 GiB");
    wr_byte(3'd5, 8'hFF);                         // bits above 39 ignored
    wr_byte(3'd1, 8'hFF);                         // bits 15:8 ignored
    probe(64'h12_EFFF_F000, "R10 ignored bits leave base");
    probe(64'hFF00_0012_E000_0000, "R7 high address bits miss");

    wr_byte(3'd0, 8'h00);                         // disable
    probe(64'h12_E000_0000, "R3 cleared enable");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule